// File: doc/BRIEF.md
# Superframe Channel Buffer with Shadow Registers

This block sits between a serial line interface and a processor. It carries a small set of byte-wide voice and signalling channels. The line side marks each 125 µs line frame with a sync pulse. Four line frames make one 500 µs superframe. Within a frame, the line delivers one received byte per channel and takes one byte per channel to transmit. Every channel holds a word with one byte lane per line frame. Lane k (bits [8k+7:8k] with the default 8-bit bytes) belongs to the k-th frame of the superframe.

Each channel has three stages. A shadow stage talks to the line. A processor receive register and a processor transmit register face the CPU. At every superframe boundary, all of them move in one clock cycle. Captured bytes go up to the CPU. Freshly written transmit words go down to the line. The block also raises a 2 kHz level interrupt at each boundary. Software then has one full superframe to read the previous one and to prepare the next.

Because of the shadow stage, a byte takes exactly two superframes from one side to the other. If a transmit word is not refreshed, it is sent again. If a receive word is not collected in time, a sticky overrun flag is set for that channel. Channels that are not enabled are frozen: their registers do not change, they send idle ones on the line, and they never raise an overrun.

Top module: `fcb_frame_buffer`

## Requirements
- R1: After reset, the interrupt is low, the enable and overrun bits are zero, and all receive and transmit words (CPU and shadow) read as all ones. A disabled channel sends 8'hFF.
- R2: A frame counter advances on each `frameSync` pulse. The 4th pulse after reset is a superframe boundary, and so is every 4th pulse after that. A byte taken on `lineValid` after k pulses since the last boundary lands in lane k, bits [8k+7:8k], of that channel's shadow receive word.
- R3: At a boundary, an enabled channel copies its shadow receive word into its CPU receive register, and the shadow receive word is refilled with all ones. Between boundaries, the CPU receive registers never change.
- R4: At a boundary, an enabled channel copies its CPU transmit register into its shadow transmit word. While in lane k, `lineTxByte` for the enabled channel on `lineCh` is lane k of that shadow word, combinationally.
- R5: Bytes received during superframe n can be read after the boundary that closes n. A word written after boundary n is sent during the superframe that starts at boundary n+1.
- R6: If no transmit word is written during a superframe, the shadow transmit word is reloaded with the unchanged value and sent again.
- R7: `cpuIrq` goes high in the cycle after a boundary and stays high until a write to the status register with bit 0 set. If that write coincides with a boundary, the interrupt stays set.
- R8: A channel's overrun bit (status bit ch+1) is set at a boundary that replaces a receive word not read since the previous boundary. A read in the same cycle as the boundary counts as a read. The bit is cleared only by writing 1 to it.
- R9: For a channel whose enable bit is 0, line bytes are not captured, the boundary copies nothing, CPU transmit writes are ignored, the line byte is 8'hFF, and no overrun is raised.
- R10: `cpuAddr` = {sel[1:0], ch}. sel=0 is the receive word (read only; a read marks it collected). sel=1 is the transmit word (read/write). sel=2 is the enable bits (bit c for channel c). sel=3 is the status register (bit 0 interrupt, bits 1..NUM_CH overrun). Receive and transmit accesses with ch ≥ NUM_CH read 0, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frameSync | input | 1 | One-cycle pulse at the start of each line frame |
| lineValid | input | 1 | Line byte strobe for channel `lineCh` |
| lineCh | input | CH_W | Channel addressed by the line side |
| lineRxByte | input | DATA_W | Byte received from the line |
| lineTxByte | output | DATA_W | Byte to transmit for `lineCh` in the current lane |
| cpuWr | input | 1 | CPU write strobe |
| cpuRd | input | 1 | CPU read strobe (marks receive words collected) |
| cpuAddr | input | CH_W+2 | CPU register address {sel, ch} |
| cpuWData | input | SLOTS*DATA_W | CPU write data |
| cpuRData | output | SLOTS*DATA_W | CPU read data, combinational from `cpuAddr` |
| cpuIrq | output | 1 | Superframe interrupt, level |

## Verification
A wrong frame count shows up at once as received bytes in the wrong lane. It also moves the interrupt edge, which is visible within one superframe. A fault in the shadow stage, such as a missed or doubled copy, appears as transmit data one superframe early or late on `lineTxByte`, or as a receive word that is stale or all ones on the next read. The receive check runs across six consecutive superframes, so any slip is seen within two boundaries. A wrong collected flag shows only through the overrun bits, one boundary after the skipped read. A fault in enable gating appears on the line byte of the disabled channel within the same cycle, and on its frozen registers at the next boundary.

// File: rtl/fcb_pkg.sv
package fcb_pkg;
  localparam int MAX_CH = 8;
  localparam int LANE_W = 4;

  typedef struct packed {
    logic              swap;
    logic [MAX_CH-1:0] wrTx;
    logic [MAX_CH-1:0] chActive;
    logic [LANE_W-1:0] lane;
  } fcb_ctl_t;
endpackage

// File: rtl/fcb_ctrl.sv
module fcb_ctrl
  import fcb_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int SLOTS  = 4,
  parameter int WORD_W = 32,
  parameter int CH_W   = 2,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frameSync,
  input  logic              cpuWr,
  input  logic              cpuRd,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [WORD_W-1:0] cpuWData,
  input  logic [WORD_W-1:0] rdRxWord,
  input  logic [WORD_W-1:0] rdTxWord,
  output fcb_ctl_t          ctl,
  output logic [CH_W-1:0]   rdCh,
  output logic [WORD_W-1:0] cpuRData,
  output logic              cpuIrq,
  output logic [NUM_CH-1:0] ovrFlags,
  output logic [NUM_CH-1:0] enFlags
);
  localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;
  localparam logic [1:0] SEL_RX = 2'd0;
  localparam logic [1:0] SEL_TX = 2'd1;
  localparam logic [1:0] SEL_EN = 2'd2;
  localparam logic [1:0] SEL_ST = 2'd3;

  logic [SLOT_W-1:0] slotIdx;
  logic              boundary;
  logic [1:0]        sel;
  logic [CH_W-1:0]   ch;
  logic              chValid;
  logic              statusWr;
  logic [NUM_CH-1:0] enReg;
  logic [NUM_CH-1:0] rxPending;
  logic [NUM_CH-1:0] ovrReg;
  logic              irqReg;

  assign sel      = cpuAddr[ADDR_W-1 -: 2];
  assign ch       = cpuAddr[CH_W-1:0];
  assign chValid  = (32'(ch) < NUM_CH);
  assign rdCh     = ch;
  assign statusWr = cpuWr && (sel == SEL_ST);
  assign boundary = frameSync && (slotIdx == SLOT_W'(SLOTS - 1));

  // frame counter inside the superframe
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slotIdx <= '0;
    end else if (frameSync) begin
      slotIdx <= boundary ? '0 : slotIdx + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enReg <= '0;
    end else if (cpuWr && (sel == SEL_EN)) begin
      enReg <= cpuWData[NUM_CH-1:0];
    end
  end

  // interrupt: set wins over acknowledge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irqReg <= 1'b0;
    end else if (boundary) begin
      irqReg <= 1'b1;
    end else if (statusWr && cpuWData[0]) begin
      irqReg <= 1'b0;
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    logic rxHit;
    logic newWord;
    assign rxHit   = cpuRd && (sel == SEL_RX) && chValid && (ch == CH_W'(c));
    assign newWord = boundary && enReg[c];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rxPending[c] <= 1'b0;
      end else if (newWord) begin
        rxPending[c] <= 1'b1;
      end else if (rxHit) begin
        rxPending[c] <= 1'b0;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ovrReg[c] <= 1'b0;
      end else if (newWord && rxPending[c] && !rxHit) begin
        ovrReg[c] <= 1'b1;
      end else if (statusWr && cpuWData[c+1]) begin
        ovrReg[c] <= 1'b0;
      end
    end
  end

  always_comb begin
    ctl      = '0;
    ctl.swap = boundary;
    ctl.lane = LANE_W'(slotIdx);
    for (int c = 0; c < NUM_CH; c++) begin
      ctl.chActive[c] = enReg[c];
      ctl.wrTx[c]     = cpuWr && (sel == SEL_TX) && chValid &&
                        (ch == CH_W'(c)) && enReg[c];
    end
  end

  always_comb begin
    cpuRData = '0;
    unique case (sel)
      SEL_RX: if (chValid) cpuRData = rdRxWord;
      SEL_TX: if (chValid) cpuRData = rdTxWord;
      SEL_EN: cpuRData[NUM_CH-1:0] = enReg;
      SEL_ST: begin
        cpuRData[0]        = irqReg;
        cpuRData[NUM_CH:1] = ovrReg;
      end
      default: cpuRData = '0;
    endcase
  end

  assign cpuIrq   = irqReg;
  assign ovrFlags = ovrReg;
  assign enFlags  = enReg;
endmodule

// File: rtl/fcb_datapath.sv
module fcb_datapath
  import fcb_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int DATA_W = 8,
  parameter int WORD_W = 32,
  parameter int CH_W   = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  fcb_ctl_t                 ctl,
  input  logic                     lineValid,
  input  logic [CH_W-1:0]          lineCh,
  input  logic [DATA_W-1:0]        lineRxByte,
  input  logic [WORD_W-1:0]        cpuWData,
  input  logic [CH_W-1:0]          rdCh,
  output logic [DATA_W-1:0]        lineTxByte,
  output logic [WORD_W-1:0]        rdRxWord,
  output logic [WORD_W-1:0]        rdTxWord,
  output logic [NUM_CH*WORD_W-1:0] rxFlat
);
  logic [WORD_W-1:0] shRx  [NUM_CH];
  logic [WORD_W-1:0] shTx  [NUM_CH];
  logic [WORD_W-1:0] rxCpu [NUM_CH];
  logic [WORD_W-1:0] txCpu [NUM_CH];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    logic capture;
    assign capture = lineValid && (lineCh == CH_W'(c)) && ctl.chActive[c];

    // line-facing shadow pair
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        shRx[c] <= '1;
        shTx[c] <= '1;
      end else if (ctl.swap && ctl.chActive[c]) begin
        shRx[c] <= '1;
        shTx[c] <= txCpu[c];
      end else if (capture) begin
        shRx[c][ctl.lane*DATA_W +: DATA_W] <= lineRxByte;
      end
    end

    // CPU-facing pair
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rxCpu[c] <= '1;
      end else if (ctl.swap && ctl.chActive[c]) begin
        rxCpu[c] <= shRx[c];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        txCpu[c] <= '1;
      end else if (ctl.wrTx[c]) begin
        txCpu[c] <= cpuWData;
      end
    end

    assign rxFlat[c*WORD_W +: WORD_W] = rxCpu[c];
  end

  always_comb begin
    lineTxByte = '1;
    for (int c = 0; c < NUM_CH; c++) begin
      if (lineCh == CH_W'(c) && ctl.chActive[c]) begin
        lineTxByte = shTx[c][ctl.lane*DATA_W +: DATA_W];
      end
    end
  end

  always_comb begin
    rdRxWord = '0;
    rdTxWord = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (rdCh == CH_W'(c)) begin
        rdRxWord = rxCpu[c];
        rdTxWord = txCpu[c];
      end
    end
  end
endmodule

// File: rtl/fcb_frame_buffer.sv
module fcb_frame_buffer
  import fcb_pkg::*;
#(
  parameter  int NUM_CH = 3,
  parameter  int DATA_W = 8,
  parameter  int SLOTS  = 4,
  localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int ADDR_W = CH_W + 2,
  localparam int WORD_W = SLOTS * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frameSync,
  input  logic              lineValid,
  input  logic [CH_W-1:0]   lineCh,
  input  logic [DATA_W-1:0] lineRxByte,
  output logic [DATA_W-1:0] lineTxByte,
  input  logic              cpuWr,
  input  logic              cpuRd,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [WORD_W-1:0] cpuWData,
  output logic [WORD_W-1:0] cpuRData,
  output logic              cpuIrq
);
  fcb_ctl_t                 ctl;
  logic [CH_W-1:0]          rdCh;
  logic [WORD_W-1:0]        rdRxWord;
  logic [WORD_W-1:0]        rdTxWord;
  logic [NUM_CH-1:0]        ovrFlags;
  logic [NUM_CH-1:0]        enFlags;
  logic [NUM_CH*WORD_W-1:0] rxFlat;

  fcb_ctrl #(
    .NUM_CH(NUM_CH), .SLOTS(SLOTS), .WORD_W(WORD_W),
    .CH_W(CH_W), .ADDR_W(ADDR_W)
  ) ctrl_i (
    .clk(clk), .rst_n(rst_n), .frameSync(frameSync),
    .cpuWr(cpuWr), .cpuRd(cpuRd), .cpuAddr(cpuAddr), .cpuWData(cpuWData),
    .rdRxWord(rdRxWord), .rdTxWord(rdTxWord),
    .ctl(ctl), .rdCh(rdCh), .cpuRData(cpuRData), .cpuIrq(cpuIrq),
    .ovrFlags(ovrFlags), .enFlags(enFlags)
  );

  fcb_datapath #(
    .NUM_CH(NUM_CH), .DATA_W(DATA_W), .WORD_W(WORD_W), .CH_W(CH_W)
  ) dp_i (
    .clk(clk), .rst_n(rst_n), .ctl(ctl),
    .lineValid(lineValid), .lineCh(lineCh), .lineRxByte(lineRxByte),
    .cpuWData(cpuWData), .rdCh(rdCh),
    .lineTxByte(lineTxByte), .rdRxWord(rdRxWord), .rdTxWord(rdTxWord),
    .rxFlat(rxFlat)
  );
endmodule

// File: rtl/fcb_frame_buffer_chk.sv
module fcb_frame_buffer_chk #(
  parameter int NUM_CH = 3,
  parameter int DATA_W = 8,
  parameter int SLOTS  = 4,
  parameter int CH_W   = 2,
  parameter int ADDR_W = 4,
  parameter int WORD_W = 32
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     swap,
  input logic                     cpuIrq,
  input logic                     cpuWr,
  input logic [ADDR_W-1:0]        cpuAddr,
  input logic [WORD_W-1:0]        cpuWData,
  input logic [NUM_CH-1:0]        ovrFlags,
  input logic [NUM_CH-1:0]        enFlags,
  input logic                     lineValid,
  input logic [CH_W-1:0]          lineCh,
  input logic [DATA_W-1:0]        lineTxByte,
  input logic [NUM_CH*WORD_W-1:0] rxFlat
);
  logic statusWr;
  logic chOn;
  assign statusWr = cpuWr && (cpuAddr[ADDR_W-1 -: 2] == 2'd3);

  always_comb begin
    chOn = 1'b0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (lineCh == CH_W'(c)) chOn = enFlags[c];
    end
  end

  // R7: interrupt follows every boundary
  p_irq_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    swap |=> cpuIrq);

  // R7: interrupt drops only after an acknowledge write
  p_irq_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cpuIrq) |-> $past(statusWr && cpuWData[0]));

  // R8: overrun bits drop only through a status write
  p_ovr_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(ovrFlags) & ~ovrFlags) != '0) |-> $past(statusWr));

  // R9: a disabled channel sends idle ones
  p_idle_tx_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (lineValid && !chOn) |-> (lineTxByte == '1));

  // R3: receive registers hold between boundaries
  p_rx_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !swap |=> $stable(rxFlat));
endmodule

bind fcb_frame_buffer fcb_frame_buffer_chk #(
  .NUM_CH(NUM_CH), .DATA_W(DATA_W), .SLOTS(SLOTS),
  .CH_W(CH_W), .ADDR_W(ADDR_W), .WORD_W(WORD_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .swap(ctl.swap), .cpuIrq(cpuIrq),
  .cpuWr(cpuWr), .cpuAddr(cpuAddr), .cpuWData(cpuWData),
  .ovrFlags(ovrFlags), .enFlags(enFlags),
  .lineValid(lineValid), .lineCh(lineCh), .lineTxByte(lineTxByte),
  .rxFlat(rxFlat)
);

// File: tb/fcb_frame_buffer_tb_top.sv
module fcb_frame_buffer_tb_top;
  localparam int NCH = 3;
  localparam int DW  = 8;
  localparam int NS  = 4;
  localparam int CHW = 2;
  localparam int AW  = 4;
  localparam int WW  = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          frameSync = 1'b0;
  logic          lineValid = 1'b0;
  logic [CHW-1:0] lineCh = '0;
  logic [DW-1:0] lineRxByte = '0;
  logic [DW-1:0] lineTxByte;
  logic          cpuWr = 1'b0;
  logic          cpuRd = 1'b0;
  logic [AW-1:0] cpuAddr = '0;
  logic [WW-1:0] cpuWData = '0;
  logic [WW-1:0] cpuRData;
  logic          cpuIrq;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // bench model of the requirements
  logic [WW-1:0] shRxM [NCH];
  logic [WW-1:0] shTxM [NCH];
  logic [WW-1:0] rxCpuM [NCH];
  logic [WW-1:0] txCpuM [NCH];
  bit            enM [NCH];
  bit            pendM [NCH];
  bit            ovM [NCH];
  int            slotM = 0;

  always #5 clk = ~clk;

  fcb_frame_buffer dut_i (
    .clk(clk), .rst_n(rst_n), .frameSync(frameSync),
    .lineValid(lineValid), .lineCh(lineCh), .lineRxByte(lineRxByte),
    .lineTxByte(lineTxByte), .cpuWr(cpuWr), .cpuRd(cpuRd),
    .cpuAddr(cpuAddr), .cpuWData(cpuWData), .cpuRData(cpuRData),
    .cpuIrq(cpuIrq)
  );

  task automatic chk(input bit ok, input string req,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] adr(input int sel, input int ch);
    return {2'(sel), CHW'(ch)};
  endfunction

  function automatic logic [DW-1:0] rxPat(input int n, input int ch, input int s);
    return DW'(n * 37 + ch * 11 + s * 5 + 3);
  endfunction

  function automatic logic [WW-1:0] txPat(input int n, input int ch);
    return WW'(n * 32'h0102_0304 + ch * 32'h1111_0000 + 32'h0A0B_0C0D);
  endfunction

  function automatic logic [WW-1:0] statusM(input bit irq);
    logic [WW-1:0] v = '0;
    v[0] = irq;
    for (int c = 0; c < NCH; c++) v[c+1] = ovM[c];
    return v;
  endfunction

  task automatic cpuWrite(input logic [AW-1:0] a, input logic [WW-1:0] d);
    @(negedge clk);
    cpuWr = 1'b1; cpuAddr = a; cpuWData = d;
    @(negedge clk);
    cpuWr = 1'b0;
  endtask

  task automatic cpuRead(input logic [AW-1:0] a, output logic [WW-1:0] d);
    @(negedge clk);
    cpuRd = 1'b1; cpuAddr = a;
    #1 d = cpuRData;
    @(negedge clk);
    cpuRd = 1'b0;
  endtask

  task automatic txWrite(input int ch, input logic [WW-1:0] d);
    cpuWrite(adr(1, ch), d);
    if (enM[ch]) txCpuM[ch] = d;
  endtask

  task automatic rxReadCheck(input int ch);
    logic [WW-1:0] d;
    cpuRead(adr(0, ch), d);
    chk(d == rxCpuM[ch], "R3 R5 receive word", d, rxCpuM[ch]);
    pendM[ch] = 0;
  endtask

  task automatic lineByte(input int ch, input logic [DW-1:0] b, input string tag);
    logic [DW-1:0] exp;
    @(negedge clk);
    lineValid = 1'b1; lineCh = CHW'(ch); lineRxByte = b;
    exp = enM[ch] ? shTxM[ch][slotM*DW +: DW] : 8'hFF;
    #1 chk(lineTxByte == exp, enM[ch] ? tag : "R9 idle line byte", lineTxByte, exp);
    @(negedge clk);
    lineValid = 1'b0;
    if (enM[ch]) shRxM[ch][slotM*DW +: DW] = b;
  endtask

  task automatic modelBoundary();
    for (int c = 0; c < NCH; c++) begin
      if (enM[c]) begin
        if (pendM[c]) ovM[c] = 1;
        rxCpuM[c] = shRxM[c];
        shRxM[c]  = '1;
        shTxM[c]  = txCpuM[c];
        pendM[c]  = 1;
      end
    end
  endtask

  // one superframe of line traffic; optional acknowledge on the boundary edge
  task automatic runSf(input int n, input string tag, input bit ackAtEdge);
    for (int s = 0; s < NS; s++) begin
      slotM = s;
      for (int c = 0; c < NCH; c++) lineByte(c, rxPat(n, c, s), tag);
      @(negedge clk);
      frameSync = 1'b1;
      if (s == NS - 1 && ackAtEdge) begin
        cpuWr = 1'b1; cpuAddr = adr(3, 0); cpuWData = 32'h1;
      end
      @(negedge clk);
      frameSync = 1'b0; cpuWr = 1'b0;
      if (s == NS - 1) modelBoundary();
      else chk(cpuIrq == 1'b0, "R2 no boundary mid-superframe", cpuIrq, 0);
    end
    slotM = 0;
  endtask

  task automatic serviceIrq();
    logic [WW-1:0] d;
    chk(cpuIrq == 1'b1, "R7 interrupt after boundary", cpuIrq, 1);
    cpuWrite(adr(3, 0), 32'h1);
    chk(cpuIrq == 1'b0, "R7 acknowledge clears", cpuIrq, 0);
    cpuRead(adr(3, 0), d);
    chk(d == statusM(0), "R8 status bits", d, statusM(0));
  endtask

  initial begin : watchdog
    #2_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : stim
    logic [WW-1:0] d;
    for (int c = 0; c < NCH; c++) begin
      shRxM[c] = '1; shTxM[c] = '1; rxCpuM[c] = '1; txCpuM[c] = '1;
      enM[c] = 0; pendM[c] = 0; ovM[c] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk(cpuIrq == 1'b0, "R1 interrupt after reset", cpuIrq, 0);
    cpuRead(adr(3, 0), d);
    chk(d == 0, "R1 status after reset", d, 0);
    cpuRead(adr(2, 0), d);
    chk(d == 0, "R1 enables after reset", d, 0);
    for (int c = 0; c < NCH; c++) begin
      cpuRead(adr(0, c), d);
      chk(d == '1, "R1 receive word after reset", d, 32'hFFFF_FFFF);
      cpuRead(adr(1, c), d);
      chk(d == '1, "R1 transmit word after reset", d, 32'hFFFF_FFFF);
    end
    lineByte(0, 8'h12, "R1");

    // R10 out-of-range channel
    cpuWrite(adr(1, 3), 32'h5555_5555);
    cpuRead(adr(1, 3), d);
    chk(d == 0, "R10 out-of-range transmit", d, 0);
    cpuRead(adr(0, 3), d);
    chk(d == 0, "R10 out-of-range receive", d, 0);

    cpuWrite(adr(2, 0), 32'h7);
    for (int c = 0; c < NCH; c++) enM[c] = 1;
    cpuRead(adr(2, 0), d);
    chk(d == 32'h7, "R10 enable readback", d, 7);

    runSf(0, "R4 transmit lane", 0);

    for (int n = 1; n <= 6; n++) begin
      serviceIrq();
      for (int c = 0; c < NCH; c++) begin
        if (!(n == 3 && c == 1)) rxReadCheck(c);
        if (n != 4) txWrite(c, txPat(n, c));
      end
      for (int c = 0; c < NCH; c++) begin
        cpuRead(adr(1, c), d);
        chk(d == txCpuM[c], "R10 transmit readback", d, txCpuM[c]);
      end
      if (n == 4) begin
        cpuRead(adr(3, 0), d);
        chk(d[2] == 1'b1, "R8 overrun after skipped read", d[2], 1);
        cpuWrite(adr(3, 0), 32'h4);
        ovM[1] = 0;
        cpuRead(adr(3, 0), d);
        chk(d == statusM(0), "R8 overrun cleared by write", d, statusM(0));
      end
      runSf(n, (n == 5) ? "R6 retransmit" : "R5 transmit latency", 0);
    end

    // R9 disable channel 2
    serviceIrq();
    cpuWrite(adr(2, 0), 32'h3);
    enM[2] = 0;
    for (int c = 0; c < 2; c++) begin
      rxReadCheck(c);
      txWrite(c, txPat(7, c));
    end
    txWrite(2, 32'hDEAD_BEEF);
    cpuRead(adr(1, 2), d);
    chk(d == txCpuM[2], "R9 disabled transmit write ignored", d, txCpuM[2]);
    runSf(7, "R4 transmit lane", 0);
    serviceIrq();
    for (int c = 0; c < NCH; c++) rxReadCheck(c);

    // R7 acknowledge coinciding with boundary
    runSf(8, "R4 transmit lane", 1);
    chk(cpuIrq == 1'b1, "R7 set wins over acknowledge", cpuIrq, 1);
    for (int c = 0; c < NCH; c++) rxReadCheck(c);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule